// File: doc/BRIEF.md
# Overcurrent and Undervoltage Fault Supervisor with Shared Enable Pin

This block supervises the shutdown path of a half-bridge gate driver. It takes three raw, asynchronous-looking inputs: an overcurrent comparator bit, a low-side undervoltage bit, and the sensed level of a single open-drain pin. That pin serves both as the external active-low enable and as the active-low fault indication. Each input passes through its own stability filter, counted in clock cycles. A filtered overcurrent trip is latched, and it stays latched for a fixed hold window that starts when the trip ends. A filtered undervoltage condition is reported for exactly as long as it lasts.

The block has two outputs. The first is a pull-low control for the shared pin: while any internal fault is active, the pin is pulled low. The pin never drives high, because an external pull-up supplies the high level. The second is a single shutdown request, which the gate control logic uses to force both gate outputs low. The request is the OR of the internal fault and a filtered low level seen on the pin. As a result, an external disable and the block's own pull-down both shut the outputs off. Both outputs come from registers.

All inputs and outputs are plain level signals. No data stream passes through the block, so no handshake or back-pressure applies.

Top module: `fault_enable_supervisor`

## Requirements
- R1: During reset and after reset, both `pin_pull_low_o` and `shutdown_o` read 1. `pin_pull_low_o` stays 1 until the undervoltage filter has seen `uv_raw_i` = 0 for `UV_FILT_CYC` consecutive cycles. It falls one clock edge after that.
- R2: An overcurrent pulse (`oc_raw_i` = 1) that lasts fewer than `OC_FILT_CYC` consecutive sampled cycles has no effect on either output. A pulse that lasts at least that long makes `pin_pull_low_o` = 1 after the edge `OC_FILT_CYC + 2` counted from its first sampling edge.
- R3: Once set, the overcurrent fault stays active while the filtered trip persists. After the trip ends, it stays active for `HOLD_CYC` more cycles: `pin_pull_low_o` falls at edge `OC_FILT_CYC + HOLD_CYC + 1` counted from the first edge that samples `oc_raw_i` = 0.
- R4: If a filtered trip reappears during the hold window, the hold count restarts. The window is then measured from the end of the new trip.
- R5: While the overcurrent fault is active, `shutdown_o` = 1.
- R6: A filtered undervoltage condition sets `pin_pull_low_o` = 1 after edge `UV_FILT_CYC + 1`. When `uv_raw_i` returns to 0, the output is released at edge `UV_FILT_CYC + 1` with no hold time.
- R7: An undervoltage dip shorter than `UV_FILT_CYC` cycles never sets `pin_pull_low_o`.
- R8: A low level on `pin_sense_i` held for `EN_FILT_CYC` cycles sets `shutdown_o` = 1 at edge `EN_FILT_CYC + 1`. This does not set `pin_pull_low_o`. The request clears at edge `EN_FILT_CYC + 1` after the pin returns high.
- R9: A low glitch on `pin_sense_i` shorter than `EN_FILT_CYC` cycles leaves `shutdown_o` at 0.
- R10: Whenever `pin_pull_low_o` = 1, `shutdown_o` = 1 as well. The block's own pull-down therefore always disables the gate outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; all filter and hold times count its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| oc_raw_i | input | 1 | Raw overcurrent comparator bit, 1 = current above threshold |
| uv_raw_i | input | 1 | Raw low-side undervoltage bit, 1 = supply below threshold |
| pin_sense_i | input | 1 | Sensed level of the shared enable/fault pin, 0 = low |
| pin_pull_low_o | output | 1 | Open-drain control, 1 = pull the shared pin low (fault) |
| shutdown_o | output | 1 | 1 = force both gate outputs low |

## Verification
The bench builds the block with `OC_FILT_CYC` = 4, `UV_FILT_CYC` = 3, `EN_FILT_CYC` = 2 and `HOLD_CYC` = 20. These values are small enough that every filter can be hit exactly one cycle below and at its threshold. They also let a full hold window expire, and a second trip restart it, within a few dozen cycles. The bench models the external pull-up as a wired AND of its own enable drive with the inverted pull-low output, so the block's pull-down loops back into its own enable filter, as it does on a board. Random overcurrent pulse widths spread across both sides of the filter threshold complement the directed latency checks.

// File: rtl/fs_pkg.sv
package fs_pkg;

  // Counter width able to hold values 0 .. n-1
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

  // Snapshot of the filtered fault sources
  typedef struct packed {
    logic oc_hold;
    logic uv_low;
    logic pin_dis;
  } fs_sources_t;

endpackage

// File: rtl/fs_glitch_filter.sv
module fs_glitch_filter #(
  parameter int unsigned STABLE_CYC = 4,
  parameter logic        INIT       = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic filt_o
);
  localparam int unsigned CW = fs_pkg::cnt_width(STABLE_CYC);
  localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

  logic          lvl_q;
  logic [CW-1:0] run_q;

  // Output follows raw input once it has differed for STABLE_CYC samples
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= INIT;
      run_q <= '0;
    end else if (raw_i == lvl_q) begin
      run_q <= '0;
    end else if (run_q == LAST) begin
      lvl_q <= raw_i;
      run_q <= '0;
    end else begin
      run_q <= run_q + CW'(1);
    end
  end

  assign filt_o = lvl_q;

  // R2 R7 R9: an input equal to the held level never moves the output
  p_filter_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_i == filt_o) |=> $stable(filt_o));

endmodule

// File: rtl/fs_trip_hold.sv
module fs_trip_hold #(
  parameter int unsigned HOLD_CYC = 11500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  output logic active_o
);
  localparam int unsigned HW = fs_pkg::cnt_width(HOLD_CYC);
  localparam logic [HW-1:0] HLAST = HW'(HOLD_CYC - 1);

  logic          act_q;
  logic [HW-1:0] hold_q;

  // Hold window restarts whenever the trip is present
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      hold_q <= '0;
    end else if (trip_i) begin
      act_q  <= 1'b1;
      hold_q <= '0;
    end else if (act_q) begin
      if (hold_q == HLAST) begin
        act_q  <= 1'b0;
        hold_q <= '0;
      end else begin
        hold_q <= hold_q + HW'(1);
      end
    end
  end

  assign active_o = act_q;

  p_trip_sets_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trip_i |=> active_o);

  p_no_drop_during_trip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(active_o) |-> !$past(trip_i));

  // R4: count stays inside the window and is idle when inactive
  p_hold_bounded_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q <= HLAST) && (active_o || hold_q == '0));

endmodule

// File: rtl/fault_enable_supervisor.sv
module fault_enable_supervisor #(
  parameter int unsigned OC_FILT_CYC = 90,
  parameter int unsigned UV_FILT_CYC = 75,
  parameter int unsigned EN_FILT_CYC = 20,
  parameter int unsigned HOLD_CYC    = 11500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_raw_i,
  input  logic uv_raw_i,
  input  logic pin_sense_i,
  output logic pin_pull_low_o,
  output logic shutdown_o
);
  import fs_pkg::*;

  logic        oc_filt;
  logic        uv_filt;
  logic        en_filt;
  fs_sources_t src;
  logic        pull_q;
  logic        shut_q;

  fs_glitch_filter #(.STABLE_CYC(OC_FILT_CYC), .INIT(1'b0)) u_oc_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(oc_raw_i), .filt_o(oc_filt));

  // Undervoltage assumed present until proven otherwise
  fs_glitch_filter #(.STABLE_CYC(UV_FILT_CYC), .INIT(1'b1)) u_uv_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(uv_raw_i), .filt_o(uv_filt));

  // Pin assumed low (disabled) until it is seen high
  fs_glitch_filter #(.STABLE_CYC(EN_FILT_CYC), .INIT(1'b0)) u_en_filt (
    .clk(clk), .rst_n(rst_n), .raw_i(pin_sense_i), .filt_o(en_filt));

  fs_trip_hold #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .trip_i(oc_filt), .active_o(src.oc_hold));

  assign src.uv_low  = uv_filt;
  assign src.pin_dis = ~en_filt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pull_q <= 1'b1;
      shut_q <= 1'b1;
    end else begin
      pull_q <= src.oc_hold | src.uv_low;
      shut_q <= src.oc_hold | src.uv_low | src.pin_dis;
    end
  end

  assign pin_pull_low_o = pull_q;
  assign shutdown_o     = shut_q;

  p_oc_shuts_r5: assert property (@(posedge clk) disable iff (!rst_n)
    src.oc_hold |=> (shutdown_o && pin_pull_low_o));

  p_uv_pulls_r6: assert property (@(posedge clk) disable iff (!rst_n)
    uv_filt |=> pin_pull_low_o);

  p_pin_low_shuts_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_filt |=> shutdown_o);

  p_pull_implies_shut_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pin_pull_low_o |-> shutdown_o);

endmodule

// File: tb/sim_fault_enable_supervisor.sv
module sim_fault_enable_supervisor;
  localparam int OCF  = 4;
  localparam int UVF  = 3;
  localparam int ENF  = 2;
  localparam int HOLD = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic oc_raw = 1'b0;
  logic uv_raw = 1'b0;
  logic ext_en = 1'b1;
  logic pin_sense;
  logic pull_low;
  logic shut;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  // Open-drain pin with external pull-up; host may also hold it low
  assign pin_sense = ext_en & ~pull_low;

  fault_enable_supervisor #(
    .OC_FILT_CYC(OCF), .UV_FILT_CYC(UVF), .EN_FILT_CYC(ENF), .HOLD_CYC(HOLD)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .oc_raw_i(oc_raw), .uv_raw_i(uv_raw),
    .pin_sense_i(pin_sense), .pin_pull_low_o(pull_low), .shutdown_o(shut));

  // Expected-value helpers derived from the requirements
  function automatic bit oc_pulse_passes(input int width);
    return width >= OCF;
  endfunction
  function automatic int oc_set_edge();
    return OCF + 2;
  endfunction
  function automatic int oc_release_edge();
    return OCF + HOLD + 1;
  endfunction

  task automatic chk(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic edges(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle_enabled();
    edges(ENF + 4);
  endtask

  initial begin
    void'($urandom(32'd2024));
    // R1: reset state
    edges(3);
    chk(pull_low, 1'b1, "R1 pull during reset");
    chk(shut, 1'b1, "R1 shutdown during reset");
    rst_n = 1'b1;
    edges(UVF);
    chk(pull_low, 1'b1, "R1 pull held until uv filter good");
    edges(1);
    chk(pull_low, 1'b0, "R1 pull released");
    settle_enabled();
    chk(shut, 1'b0, "R8 shutdown clear with pin high");

    // R2 R5: overcurrent latency
    oc_raw = 1'b1;
    edges(oc_set_edge() - 1);
    chk(pull_low, 1'b0, "R2 not yet set");
    edges(1);
    chk(pull_low, 1'b1, "R2 trip sets fault");
    chk(shut, 1'b1, "R5 trip shuts outputs");
    edges(4);
    // R3: hold after trip ends
    oc_raw = 1'b0;
    edges(oc_release_edge() - 1);
    chk(pull_low, 1'b1, "R3 still held");
    chk(shut, 1'b1, "R5 shutdown during hold");
    edges(1);
    chk(pull_low, 1'b0, "R3 released after hold");
    settle_enabled();
    chk(shut, 1'b0, "R3 shutdown released");

    // R4: retrigger restarts the window
    oc_raw = 1'b1;
    edges(OCF + 3);
    oc_raw = 1'b0;
    edges(OCF + HOLD / 2);
    oc_raw = 1'b1;
    edges(OCF + 2);
    oc_raw = 1'b0;
    edges(oc_release_edge() - 1);
    chk(pull_low, 1'b1, "R4 hold restarted");
    edges(1);
    chk(pull_low, 1'b0, "R4 released after new window");
    settle_enabled();

    // R6: undervoltage, no hold
    uv_raw = 1'b1;
    edges(UVF);
    chk(pull_low, 1'b0, "R6 uv not yet");
    edges(1);
    chk(pull_low, 1'b1, "R6 uv sets fault");
    chk(shut, 1'b1, "R10 own pull shuts");
    edges(5);
    uv_raw = 1'b0;
    edges(UVF);
    chk(pull_low, 1'b1, "R6 uv still filtered");
    edges(1);
    chk(pull_low, 1'b0, "R6 uv released without hold");
    settle_enabled();
    chk(shut, 1'b0, "R6 shutdown released");

    // R7: short dip ignored
    begin
      bit seen = 1'b0;
      uv_raw = 1'b1;
      for (int i = 0; i < UVF - 1; i++) begin
        @(negedge clk);
        seen |= pull_low;
      end
      uv_raw = 1'b0;
      for (int i = 0; i < UVF + 3; i++) begin
        @(negedge clk);
        seen |= pull_low;
      end
      chk(seen, 1'b0, "R7 short uv dip ignored");
    end

    // R8: external disable
    ext_en = 1'b0;
    edges(ENF);
    chk(shut, 1'b0, "R8 not yet disabled");
    edges(1);
    chk(shut, 1'b1, "R8 pin low disables");
    chk(pull_low, 1'b0, "R8 no pull on external disable");
    ext_en = 1'b1;
    edges(ENF);
    chk(shut, 1'b1, "R8 still disabled while filtering");
    edges(1);
    chk(shut, 1'b0, "R8 enable restored");

    // R9: short pin glitch
    begin
      bit seen = 1'b0;
      ext_en = 1'b0;
      for (int i = 0; i < ENF - 1; i++) begin
        @(negedge clk);
        seen |= shut;
      end
      ext_en = 1'b1;
      for (int i = 0; i < ENF + 3; i++) begin
        @(negedge clk);
        seen |= shut;
      end
      chk(seen, 1'b0, "R9 short pin glitch ignored");
    end

    // R2 R3: random overcurrent pulse widths around the threshold
    for (int k = 0; k < 24; k++) begin
      int w;
      w = 1 + int'($urandom_range(2 * OCF));
      oc_raw = 1'b1;
      edges(w);
      oc_raw = 1'b0;
      edges(3);
      chk(pull_low, oc_pulse_passes(w), $sformatf("R2 random width %0d", w));
      edges(OCF + HOLD + 2);
      chk(pull_low, 1'b0, "R3 random release");
      settle_enabled();
      chk(shut, 1'b0, "R10 random shutdown clear");
    end

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule